// File: doc/BRIEF.md
# USB Function Register and Interrupt Bank

This block is the software-visible register bank of a full-speed USB device function. A processor reaches it through a simple slave port that carries a byte offset, a write strobe, 32-bit write data and combinational read data. It holds the global control word, the device address, a status word and a 4-bit configuration word for each endpoint. The status word mirrors the frame number and the bus line state. It also carries two sticky flags, one for bus reset and one for start-of-frame. A combined interrupt word holds one sticky receive-ready flag and one sticky transmit-complete flag per endpoint.

The packet engines pulse event inputs for one cycle. The block latches each pulse and exposes it to software, then ANDs the flags with the enables held in the endpoint configuration words and the control word. The result drives one interrupt line. Software clears endpoint flags by writing ones. It clears the status flags by writing anything to the status word. Stall, isochronous, control and address settings leave the block as plain outputs for the rest of the function.

Top module: `usbf_csr_bank`

## Requirements
- R1: After reset, every register, every sticky flag, every configuration output and `irq` are zero.
- R2: The control word at offset 0x00 stores write data bits 8:0, reads them back in bits 8:0 with zeros above, and drives `func_ctrl`. Bit 0 is the start-of-frame interrupt enable.
- R3: The device address word at offset 0x08 stores write data bits 6:0, reads them back in bits 6:0, and drives `dev_addr`. Its value changes only on a write to 0x08.
- R4: The status word at offset 0x04 reads the following fields:
  - bits 10:0: the live `frame_num` input;
  - bits 12:11: the live `line_state` input, with D+ in bit 12;
  - bit 13: a flag set by a `bus_reset_evt` pulse;
  - bit 14: a flag set by a `sof_evt` pulse.
- R5: Any write to offset 0x04 clears bits 13 and 14, whatever the data. If an event pulse for one of those flags arrives in the same cycle as the write, that flag stays set.
- R6: The configuration word of endpoint i sits at offset 0x20 + 0x20*i and holds 4 bits:
  - bit 3: receive-ready interrupt enable;
  - bit 2: transmit-complete interrupt enable;
  - bit 1: stall, driven on `ep_stall[i]`;
  - bit 0: isochronous, driven on `ep_iso[i]`.
- R7: The combined interrupt word at offset 0x0C reads the receive-ready flag of endpoint i in bit i and its transmit-complete flag in bit 16+i. A pulse on `rx_ready_evt[i]` or `tx_done_evt[i]` sets the flag whatever the enables.
- R8: A write to 0x0C clears each interrupt flag whose write data bit is 1 and leaves the flags under 0 bits unchanged. If an event pulse for a flag arrives in the same cycle as its clear, the flag stays set.
- R9: `irq` is high exactly when at least one of these holds:
  - a receive-ready flag is set and its endpoint's bit 3 is set;
  - a transmit-complete flag is set and its endpoint's bit 2 is set;
  - the start-of-frame flag is set and control bit 0 is set.
- R10: The following read zero, and writes to them change nothing:
  - unmapped offsets;
  - offsets whose two low bits are not zero;
  - offsets +0x4 to +0x1C inside an endpoint group;
  - the group of any endpoint at or beyond NUM_EP (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_ready_evt | input | NUM_EP | Receive-ready pulse per endpoint |
| tx_done_evt | input | NUM_EP | Transmit-complete pulse per endpoint |
| sof_evt | input | 1 | Start-of-frame received pulse |
| bus_reset_evt | input | 1 | Bus reset detected pulse |
| line_state | input | 2 | Line state, bit 1 is D+ |
| frame_num | input | 11 | Current frame number |
| func_ctrl | output | 9 | Control word contents |
| dev_addr | output | 7 | Device address |
| ep_stall | output | NUM_EP | Stall setting per endpoint |
| ep_iso | output | NUM_EP | Isochronous setting per endpoint |
| irq | output | 1 | Merged interrupt request |

## Verification
The hazard that matters is a hardware event pulse that lands in the same clock as a software clear of the same sticky flag. This can happen to an endpoint flag cleared through the combined interrupt word, or to a status flag cleared by a write to the status word. Directed cases set a flag first and then issue the clear together with a fresh pulse. The flag must still read as set, and `irq` must follow the enables. Random cycles mix writes to all offsets, including dead ones, with event pulses on every input. This makes such overlaps frequent, and a bench model that gives the event priority judges each one.

// File: rtl/usbf_csr_pkg.sv
package usbf_csr_pkg;

    localparam int MAX_EP       = 16;
    localparam int DATA_W       = 32;
    localparam int CTRL_W       = 9;
    localparam int DADDR_W      = 7;
    localparam int CFG_W        = 4;
    localparam int FRAME_W      = 11;

    // global word offsets (byte addressed, word aligned)
    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_DADR = 5'h08;
    localparam logic [4:0] OFS_INTS = 5'h0C;

    // group geometry: one 32-byte group per endpoint, group 0 is global
    localparam int GRP_SHIFT    = 5;

    // config word bit positions
    localparam int CFG_ISO      = 0;
    localparam int CFG_STALL    = 1;
    localparam int CFG_TX_IE    = 2;
    localparam int CFG_RX_IE    = 3;

    // status word positions
    localparam int STAT_LINE_LSB = 11;
    localparam int STAT_RST_BIT  = 13;
    localparam int STAT_SOF_BIT  = 14;

    // combined interrupt word: transmit flags start here
    localparam int INTS_TX_LSB  = 16;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [DADDR_W-1:0] dev_addr;
        logic               rst_flag;
        logic               sof_pend;
    } glob_regs_t;

endpackage

// File: rtl/usbf_csr_decode.sv
module usbf_csr_decode
    import usbf_csr_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_ctrl,
    output logic              sel_stat,
    output logic              sel_dadr,
    output logic              sel_ints,
    output logic [NUM_EP-1:0] sel_cfg
);

    localparam int GRP_W = ADDR_W - GRP_SHIFT;

    logic [GRP_W-1:0] grp;
    logic [4:0]       ofs;

    assign grp = addr[ADDR_W-1:GRP_SHIFT];
    assign ofs = addr[GRP_SHIFT-1:0];

    always_comb begin
        sel_ctrl = 1'b0;
        sel_stat = 1'b0;
        sel_dadr = 1'b0;
        sel_ints = 1'b0;
        sel_cfg  = '0;
        if (grp == '0) begin
            case (ofs)
                OFS_CTRL: sel_ctrl = 1'b1;
                OFS_STAT: sel_stat = 1'b1;
                OFS_DADR: sel_dadr = 1'b1;
                OFS_INTS: sel_ints = 1'b1;
                default:  ;
            endcase
        end else if (ofs == 5'h00) begin
            for (int i = 0; i < NUM_EP; i++) begin
                if (grp == GRP_W'(i + 1)) sel_cfg[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/usbf_ep_bank.sv
module usbf_ep_bank
    import usbf_csr_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_EP-1:0]            cfg_we,
    input  logic                         ints_we,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_EP-1:0]            rx_evt,
    input  logic [NUM_EP-1:0]            tx_evt,
    output logic [NUM_EP-1:0][CFG_W-1:0] cfg,
    output logic [NUM_EP-1:0]            rx_pend,
    output logic [NUM_EP-1:0]            tx_pend,
    output logic [NUM_EP-1:0]            rx_ie,
    output logic [NUM_EP-1:0]            tx_ie,
    output logic [NUM_EP-1:0]            stall,
    output logic [NUM_EP-1:0]            iso
);

    typedef struct packed {
        logic [NUM_EP-1:0][CFG_W-1:0] cfg;
        logic [NUM_EP-1:0]            rxp;
        logic [NUM_EP-1:0]            txp;
    } ep_state_t;

    ep_state_t st_d, st_q;

    logic [NUM_EP-1:0] rx_clr, tx_clr;

    always_comb begin
        st_d   = st_q;
        rx_clr = ints_we ? wdata[NUM_EP-1:0]           : '0;
        tx_clr = ints_we ? wdata[INTS_TX_LSB +: NUM_EP] : '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (cfg_we[i]) st_d.cfg[i] = wdata[CFG_W-1:0];
        end
        // a pulse in the clearing cycle keeps its flag set
        st_d.rxp = (st_q.rxp & ~rx_clr) | rx_evt;
        st_d.txp = (st_q.txp & ~tx_clr) | tx_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign rx_pend = st_q.rxp;
    assign tx_pend = st_q.txp;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        assign rx_ie[g] = st_q.cfg[g][CFG_RX_IE];
        assign tx_ie[g] = st_q.cfg[g][CFG_TX_IE];
        assign stall[g] = st_q.cfg[g][CFG_STALL];
        assign iso[g]   = st_q.cfg[g][CFG_ISO];
    end

    // R7 / R8: a pulse always leaves its flag set after the edge
    a_r8_rx_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_evt) |=> ((rx_pend & $past(rx_evt)) == $past(rx_evt)));

    a_r8_tx_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_evt) |=> ((tx_pend & $past(tx_evt)) == $past(tx_evt)));

    // R8: a clear without a competing pulse empties the flag
    a_r8_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ints_we && (|(wdata[INTS_TX_LSB +: NUM_EP] & ~tx_evt)))
        |=> ((tx_pend & $past(wdata[INTS_TX_LSB +: NUM_EP] & ~tx_evt)) == '0));

    // R6: config words move only on a decoded write
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we == '0) |=> $stable(cfg));

endmodule

// File: rtl/usbf_csr_bank.sv
module usbf_csr_bank
    import usbf_csr_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_EP-1:0]   rx_ready_evt,
    input  logic [NUM_EP-1:0]   tx_done_evt,
    input  logic                sof_evt,
    input  logic                bus_reset_evt,
    input  logic [1:0]          line_state,
    input  logic [10:0]         frame_num,
    output logic [8:0]          func_ctrl,
    output logic [6:0]          dev_addr,
    output logic [NUM_EP-1:0]   ep_stall,
    output logic [NUM_EP-1:0]   ep_iso,
    output logic                irq
);

    logic                         sel_ctrl, sel_stat, sel_dadr, sel_ints;
    logic [NUM_EP-1:0]            sel_cfg;
    logic [NUM_EP-1:0][CFG_W-1:0] ep_cfg;
    logic [NUM_EP-1:0]            rx_pend, tx_pend, rx_ie, tx_ie;
    logic                         any_sel;

    glob_regs_t g_d, g_q;

    usbf_csr_decode #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .sel_ctrl (sel_ctrl),
        .sel_stat (sel_stat),
        .sel_dadr (sel_dadr),
        .sel_ints (sel_ints),
        .sel_cfg  (sel_cfg)
    );

    usbf_ep_bank #(.NUM_EP(NUM_EP)) u_ep (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (sel_cfg & {NUM_EP{bus_we}}),
        .ints_we (bus_we & sel_ints),
        .wdata   (bus_wdata),
        .rx_evt  (rx_ready_evt),
        .tx_evt  (tx_done_evt),
        .cfg     (ep_cfg),
        .rx_pend (rx_pend),
        .tx_pend (tx_pend),
        .rx_ie   (rx_ie),
        .tx_ie   (tx_ie),
        .stall   (ep_stall),
        .iso     (ep_iso)
    );

    // global registers
    always_comb begin
        g_d = g_q;
        if (bus_we && sel_ctrl) g_d.ctrl     = bus_wdata[CTRL_W-1:0];
        if (bus_we && sel_dadr) g_d.dev_addr = bus_wdata[DADDR_W-1:0];
        if (bus_we && sel_stat) begin
            g_d.rst_flag = 1'b0;
            g_d.sof_pend = 1'b0;
        end
        if (bus_reset_evt) g_d.rst_flag = 1'b1;
        if (sof_evt)       g_d.sof_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) bus_rdata[CTRL_W-1:0]  = g_q.ctrl;
        if (sel_dadr) bus_rdata[DADDR_W-1:0] = g_q.dev_addr;
        if (sel_stat) begin
            bus_rdata[FRAME_W-1:0]               = frame_num;
            bus_rdata[STAT_LINE_LSB +: 2]        = line_state;
            bus_rdata[STAT_RST_BIT]              = g_q.rst_flag;
            bus_rdata[STAT_SOF_BIT]              = g_q.sof_pend;
        end
        if (sel_ints) begin
            bus_rdata[NUM_EP-1:0]            = rx_pend;
            bus_rdata[INTS_TX_LSB +: NUM_EP] = tx_pend;
        end
        for (int i = 0; i < NUM_EP; i++) begin
            if (sel_cfg[i]) bus_rdata[CFG_W-1:0] = ep_cfg[i];
        end
    end

    assign func_ctrl = g_q.ctrl;
    assign dev_addr  = g_q.dev_addr;
    assign any_sel   = sel_ctrl | sel_stat | sel_dadr | sel_ints | (|sel_cfg);

    assign irq = (|(rx_pend & rx_ie)) | (|(tx_pend & tx_ie)) | (g_q.sof_pend & g_q.ctrl[0]);

    // R3: address register moves only on its own write
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && sel_dadr) |=> $stable(dev_addr));

    // R4: bus reset pulse sets the flag
    a_r4_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> g_q.rst_flag);

    // R5: a status write without a pulse leaves the sof flag clear
    a_r5_sof_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_stat && !sof_evt) |=> !g_q.sof_pend);

    // R9: no pending source, no interrupt
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pend == '0 && tx_pend == '0 && !g_q.sof_pend) |-> !irq);

    // R10: unmapped offsets read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !any_sel |-> (bus_rdata == '0));

    // at most one target per offset
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ctrl, sel_stat, sel_dadr, sel_ints, sel_cfg}));

endmodule

// File: tb/usbf_csr_bank_test.sv
module usbf_csr_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NE-1:0] rx_ready_evt = '0, tx_done_evt = '0;
    logic        sof_evt = 1'b0, bus_reset_evt = 1'b0;
    logic [1:0]  line_state = '0;
    logic [10:0] frame_num = '0;
    logic [8:0]  func_ctrl;
    logic [6:0]  dev_addr;
    logic [NE-1:0] ep_stall, ep_iso;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [8:0]  m_ctrl = '0;
    logic [6:0]  m_addr = '0;
    logic        m_rst = 1'b0, m_sof = 1'b0;
    logic [3:0]  m_cfg [NE];
    logic [NE-1:0] m_rxp = '0, m_txp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbf_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_ready_evt(rx_ready_evt), .tx_done_evt(tx_done_evt),
        .sof_evt(sof_evt), .bus_reset_evt(bus_reset_evt),
        .line_state(line_state), .frame_num(frame_num),
        .func_ctrl(func_ctrl), .dev_addr(dev_addr),
        .ep_stall(ep_stall), .ep_iso(ep_iso), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // endpoint index from offset, -1 if not a live config word
    function automatic int cfg_index(input logic [11:0] a);
        int grp;
        grp = int'(a[11:5]);
        if (a[4:0] != 5'h00 || grp < 1 || grp > NE) return -1;
        return grp - 1;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [31:0] r;
        int e;
        r = '0;
        e = cfg_index(a);
        case (a)
            12'h000: r[8:0] = m_ctrl;
            12'h004: r = {17'b0, m_sof, m_rst, line_state, frame_num};
            12'h008: r[6:0] = m_addr;
            12'h00C: begin r[NE-1:0] = m_rxp; r[16 +: NE] = m_txp; end
            default: if (e >= 0) r[3:0] = m_cfg[e];
        endcase
        return r;
    endfunction

    function automatic logic exp_irq();
        logic v;
        v = m_sof & m_ctrl[0];
        for (int i = 0; i < NE; i++) begin
            v |= (m_rxp[i] & m_cfg[i][3]) | (m_txp[i] & m_cfg[i][2]);
        end
        return v;
    endfunction

    function automatic logic [NE-1:0] exp_bit(input int b);
        logic [NE-1:0] v;
        for (int i = 0; i < NE; i++) v[i] = m_cfg[i][b];
        return v;
    endfunction

    // one clock of stimulus, model update, and output checks
    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] wd,
                        input logic [NE-1:0] rxe, input logic [NE-1:0] txe,
                        input logic sofe, input logic rste);
        int e;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd;
        rx_ready_evt = rxe; tx_done_evt = txe; sof_evt = sofe; bus_reset_evt = rste;
        if (we) begin
            e = cfg_index(a);
            if (a == 12'h000) m_ctrl = wd[8:0];
            if (a == 12'h008) m_addr = wd[6:0];
            if (a == 12'h004) begin m_rst = 1'b0; m_sof = 1'b0; end
            if (a == 12'h00C) begin
                m_rxp &= ~wd[NE-1:0];
                m_txp &= ~wd[16 +: NE];
            end
            if (e >= 0) m_cfg[e] = wd[3:0];
        end
        m_rxp |= rxe; m_txp |= txe;
        if (sofe) m_sof = 1'b1;
        if (rste) m_rst = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0; rx_ready_evt = '0; tx_done_evt = '0; sof_evt = 1'b0; bus_reset_evt = 1'b0;
        check("R9 irq", {31'b0, irq}, {31'b0, exp_irq()});
        check("R2 func_ctrl", {23'b0, func_ctrl}, {23'b0, m_ctrl});
        check("R3 dev_addr", {25'b0, dev_addr}, {25'b0, m_addr});
        check("R6 ep_stall", {28'b0, ep_stall}, {28'b0, exp_bit(1)});
        check("R6 ep_iso", {28'b0, ep_iso}, {28'b0, exp_bit(0)});
    endtask

    task automatic rd(input string tag, input logic [11:0] a);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_rd(a));
    endtask

    localparam logic [11:0] ADDRS [20] = '{
        12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h01C, 12'h020, 12'h024,
        12'h028, 12'h02C, 12'h030, 12'h040, 12'h060, 12'h080, 12'h0A0, 12'h1E0,
        12'h200, 12'h022, 12'h041, 12'h00E };

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1D5E_0042;
        void'($urandom(seed));
        for (int i = 0; i < NE; i++) m_cfg[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        rd("R1 ctrl reset", 12'h000);
        rd("R1 stat reset", 12'h004);
        rd("R1 addr reset", 12'h008);
        rd("R1 ints reset", 12'h00C);
        rd("R1 cfg0 reset", 12'h020);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3 directed
        step(1'b1, 12'h000, 32'hFFFF_FFFF, '0, '0, 1'b0, 1'b0);
        rd("R2 ctrl upper zero", 12'h000);
        step(1'b1, 12'h008, 32'h0000_00D5, '0, '0, 1'b0, 1'b0);
        rd("R3 addr read", 12'h008);

        // R4: live fields and sticky flags
        frame_num = 11'h5A3; line_state = 2'b10;
        step(1'b0, 12'h000, '0, '0, '0, 1'b1, 1'b1);
        rd("R4 status fields", 12'h004);
        // R5: clear with same-cycle sof pulse, reset flag must clear
        step(1'b1, 12'h004, 32'h0, '0, '0, 1'b1, 1'b0);
        rd("R5 sof wins clear", 12'h004);
        step(1'b1, 12'h004, 32'h0, '0, '0, 1'b0, 1'b0);
        rd("R5 cleared", 12'h004);

        // R6 config, R7 latch without enable
        step(1'b1, 12'h040, 32'h0000_000B, '0, '0, 1'b0, 1'b0);
        rd("R6 cfg1", 12'h040);
        step(1'b0, 12'h000, '0, 4'b0100, 4'b0010, 1'b0, 1'b0);
        rd("R7 latch regardless of enable", 12'h00C);
        // R8 collision: clear rx1 and tx1 with fresh pulses
        step(1'b0, 12'h000, '0, 4'b0010, '0, 1'b0, 1'b0);
        step(1'b1, 12'h00C, 32'h0002_0002, 4'b0010, 4'b0010, 1'b0, 1'b0);
        rd("R8 event wins over clear", 12'h00C);
        step(1'b1, 12'h00C, 32'h0002_0000, '0, '0, 1'b0, 1'b0);
        rd("R8 selective clear", 12'h00C);

        // R10: dead offsets ignore writes
        step(1'b1, 12'h0A0, 32'h0000_000F, '0, '0, 1'b0, 1'b0);
        rd("R10 ep4 reads zero", 12'h0A0);
        step(1'b1, 12'h024, 32'hFFFF_FFFF, '0, '0, 1'b0, 1'b0);
        rd("R10 tx ctrl offset zero", 12'h024);
        step(1'b1, 12'h022, 32'h0000_000F, '0, '0, 1'b0, 1'b0);
        rd("R10 unaligned ignored cfg0", 12'h020);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [31:0] wd;
            a  = ADDRS[$urandom_range(19)];
            wd = $urandom();
            frame_num  = 11'($urandom());
            line_state = 2'($urandom());
            step(($urandom_range(2) == 0), a, wd,
                 NE'($urandom() & $urandom()), NE'($urandom() & $urandom()),
                 ($urandom_range(5) == 0), ($urandom_range(9) == 0));
            rd("R7 R10 random read", ADDRS[$urandom_range(19)]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule